// File: doc/BRIEF.md
# Interrupt Level Acceptance Controller

This block decides, cycle by cycle, whether the processor takes one of its 24 peripheral interrupt requests. Each request line gets a 2-bit priority level from a bank of packed level registers. A global interrupt enable flag and a 2-bit running level set the bar a request must clear. Level 0 is the most urgent. Level 3 means that no handler is active, so a request programmed to level 3 is never taken.

In every cycle the controller picks the most urgent pending request. A pick is accepted only when the enable flag is set and the request's level is numerically below the running level. On acceptance the controller does four things: it raises a registered accept flag with the request number, pushes the old running level onto a small stack, loads the accepted level and clears the enable flag. The accept flag stays up until the processor acknowledges it. A return strobe pops the saved level and sets the enable flag again, which lets handlers nest from level 2 down to level 0 and unwind in reverse order.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset, `ien` is 0, `run_level` is 3, `accept` is 0, and every request level field reads 3.
- R2: Level register `n` (written with `cfg_we` and `cfg_addr`=n, n from 0 to 5) holds the levels of requests 4n to 4n+3. Request 4n+k sits in bits 2k+1:2k. A write to address 6 or 7 changes nothing. A write affects acceptance from the following cycle.
- R3: `ien_set` sets `ien` and `ien_clr` clears it at the next edge. When both are high, clear wins. While `ien` is 0, no request is accepted.
- R4: A pending request is accepted only if its level is strictly less than `run_level`. A request at level 3 is never accepted.
- R5: Among qualifying requests, the lowest level value wins. Among requests of equal level, the lowest request number wins.
- R6: `accept` and `accept_id` are registered. They rise at the edge that sees the qualifying condition, hold steady until `ack` is sampled high, and no further acceptance occurs while `accept` is high.
- R7: At the accepting edge, `run_level` becomes the accepted level and `ien` becomes 0. Acceptance overrides an `ien_set` strobe in the same cycle.
- R8: `ret` loads `run_level` with the most recently saved level and sets `ien` at the next edge. No acceptance is made in a cycle in which `ret` is high.
- R9: `ret` with no saved level loads `run_level` with 3 and sets `ien`.
- R10: Saved levels are restored last-in first-out, through up to three nested acceptances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 24 | Pending request lines, bit i is request i |
| cfg_we | input | 1 | Level register write strobe |
| cfg_addr | input | 3 | Level register index |
| cfg_wdata | input | 8 | Level register write data, four 2-bit fields |
| ien_set | input | 1 | Set the interrupt enable flag |
| ien_clr | input | 1 | Clear the interrupt enable flag |
| ack | input | 1 | Processor has taken the accepted request |
| ret | input | 1 | Handler return: restore saved level, re-enable |
| accept | output | 1 | A request has been accepted and awaits acknowledge |
| accept_id | output | 5 | Number of the accepted request |
| run_level | output | 2 | Current running level (3 = no handler active) |
| ien | output | 1 | Interrupt enable flag |

## Verification
Acceptance and an enable-set strobe can land in the same cycle. The bench arranges this by asserting a new urgent request in the very cycle that `ien_set` is pulsed while the flag is already 1. It expects `ien` to read 0 afterwards, with the acceptance recorded in the scoreboard. A return strobe can also coincide with a request that would qualify against the restored level. The bench checks that nothing is accepted in the return cycle and that the acceptance appears, with the expected number and level, exactly one cycle later.

// File: rtl/irqlv_pkg.sv
package irqlv_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_IDLE = '1;
endpackage

// File: rtl/irqlv_level_regs.sv
module irqlv_level_regs
  import irqlv_pkg::*;
#(
  parameter int NUM_REQ = 24,
  parameter int REG_W = 8,
  localparam int NUM_REGS = (NUM_REQ * LVL_W) / REG_W,
  localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [REG_W-1:0]          wdata,
  output logic [NUM_REQ*LVL_W-1:0]  lvl_flat
);
  localparam logic [ADDR_W:0] REG_CNT = (ADDR_W + 1)'(NUM_REGS);

  logic [REG_W-1:0] bank [NUM_REGS];
  logic             addr_ok;

  assign addr_ok = ({1'b0, addr} < REG_CNT);

  // one register per bank slot; reset to all ones so every request starts at level 3
  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
      always_ff @(posedge clk) begin
        if (rst) begin
          bank[g] <= '1;
        end else if (we && addr_ok && (addr == ADDR_W'(g))) begin
          bank[g] <= wdata;
        end
      end
      assign lvl_flat[g*REG_W +: REG_W] = bank[g];
    end
  endgenerate

  // R2: a write outside the bank leaves every level field alone
  a_r2_bad_addr_ignored: assert property (@(posedge clk) disable iff (rst)
    (we && !addr_ok) |=> $stable(lvl_flat));
endmodule

// File: rtl/irqlv_select.sv
module irqlv_select
  import irqlv_pkg::*;
#(
  parameter int NUM_REQ = 24,
  localparam int ID_W = $clog2(NUM_REQ)
) (
  input  logic [NUM_REQ-1:0]        req,
  input  logic [NUM_REQ*LVL_W-1:0]  lvl_flat,
  input  lvl_t                      cur_lvl,
  output logic                      found,
  output logic [ID_W-1:0]           win_id,
  output lvl_t                      win_lvl
);
  lvl_t req_lvl [NUM_REQ];

  generate
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_unpack
      assign req_lvl[g] = lvl_flat[g*LVL_W +: LVL_W];
    end
  endgenerate

  // scan upward; only a strictly lower level displaces the current pick,
  // so the lowest index wins among equal levels
  always_comb begin
    found   = 1'b0;
    win_id  = '0;
    win_lvl = LVL_IDLE;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (req[i] && (req_lvl[i] < cur_lvl) && (!found || (req_lvl[i] < win_lvl))) begin
        found   = 1'b1;
        win_id  = ID_W'(i);
        win_lvl = req_lvl[i];
      end
    end
  end
endmodule

// File: rtl/irqlv_level_stack.sv
module irqlv_level_stack
  import irqlv_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  lvl_t push_lvl,
  output lvl_t pop_lvl
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  lvl_t            mem [DEPTH];
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   wr_idx;
  logic [IW-1:0]   rd_idx;

  assign wr_idx  = cnt[IW-1:0];
  assign rd_idx  = IW'(cnt - 1'b1);
  assign pop_lvl = (cnt == '0) ? LVL_IDLE : mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (push && (cnt != FULL)) begin
      cnt <= cnt + 1'b1;
    end else if (pop && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  // storage without reset, one write port
  always_ff @(posedge clk) begin
    if (push && (cnt != FULL)) begin
      mem[wr_idx] <= push_lvl;
    end
  end

  // R10: nesting never exceeds the number of levels below idle
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt != FULL));
  // R8: a return never coincides with a new acceptance
  a_r8_no_push_on_pop: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irqlv_pkg::*;
#(
  parameter int NUM_REQ = 24,
  parameter int REG_W = 8,
  localparam int NUM_REGS = (NUM_REQ * LVL_W) / REG_W,
  localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int ID_W = $clog2(NUM_REQ),
  localparam int NEST = (1 << LVL_W) - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REQ-1:0]  irq_req,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [REG_W-1:0]    cfg_wdata,
  input  logic                ien_set,
  input  logic                ien_clr,
  input  logic                ack,
  input  logic                ret,
  output logic                accept,
  output logic [ID_W-1:0]     accept_id,
  output logic [LVL_W-1:0]    run_level,
  output logic                ien
);
  logic [NUM_REQ*LVL_W-1:0] lvl_flat;
  logic                     found;
  logic [ID_W-1:0]          win_id;
  lvl_t                     win_lvl;
  lvl_t                     pop_lvl;
  logic                     fire;

  logic                     accept_q;
  logic [ID_W-1:0]          id_q;
  lvl_t                     run_q;
  logic                     ien_q;

  irqlv_level_regs #(.NUM_REQ(NUM_REQ), .REG_W(REG_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .lvl_flat (lvl_flat)
  );

  irqlv_select #(.NUM_REQ(NUM_REQ)) u_select (
    .req      (irq_req),
    .lvl_flat (lvl_flat),
    .cur_lvl  (run_q),
    .found    (found),
    .win_id   (win_id),
    .win_lvl  (win_lvl)
  );

  irqlv_level_stack #(.DEPTH(NEST)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (fire),
    .pop      (ret),
    .push_lvl (run_q),
    .pop_lvl  (pop_lvl)
  );

  // one outstanding acceptance at a time; a return cycle takes no new request
  assign fire = ien_q && found && !accept_q && !ret;

  always_ff @(posedge clk) begin
    if (rst) begin
      accept_q <= 1'b0;
      id_q     <= '0;
      run_q    <= LVL_IDLE;
      ien_q    <= 1'b0;
    end else if (fire) begin
      accept_q <= 1'b1;
      id_q     <= win_id;
      run_q    <= win_lvl;
      ien_q    <= 1'b0;
    end else begin
      if (accept_q && ack) begin
        accept_q <= 1'b0;
      end
      if (ret) begin
        run_q <= pop_lvl;
        ien_q <= 1'b1;
      end else if (ien_clr) begin
        ien_q <= 1'b0;
      end else if (ien_set) begin
        ien_q <= 1'b1;
      end
    end
  end

  assign accept    = accept_q;
  assign accept_id = id_q;
  assign run_level = run_q;
  assign ien       = ien_q;

  // R3: with the flag clear, no acceptance can start
  a_r3_disabled_blocks: assert property (@(posedge clk) disable iff (rst)
    (!ien_q && !accept_q) |=> !accept_q);
  // R4: an accepted level is always strictly below the level it interrupted
  a_r4_strictly_lower: assert property (@(posedge clk) disable iff (rst)
    $rose(accept_q) |-> (run_q < $past(run_q)));
  // R5: the selected request is pending and qualifies against the running level
  a_r5_winner_pending: assert property (@(posedge clk) disable iff (rst)
    found |-> (irq_req[win_id] && (win_lvl < run_q)));
  // R6: accept and its number hold until acknowledged
  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (accept_q && !ack) |=> (accept_q && $stable(id_q)));
  // R7: acceptance leaves the enable flag clear
  a_r7_accept_disables: assert property (@(posedge clk) disable iff (rst)
    $rose(accept_q) |-> !ien_q);
  // R8: a return re-enables and starts no acceptance
  a_r8_return_enables: assert property (@(posedge clk) disable iff (rst)
    (ret && !accept_q) |=> (ien_q && !accept_q));
endmodule

// File: tb/irq_accept_ctrl_tb.sv
module irq_accept_ctrl_tb;
  typedef struct {
    int id;
    int lvl;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] irq_req = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        ien_set = 1'b0;
  logic        ien_clr = 1'b0;
  logic        ack = 1'b0;
  logic        ret = 1'b0;
  logic        accept;
  logic [4:0]  accept_id;
  logic [1:0]  run_level;
  logic        ien;

  int   checks = 0;
  int   failures = 0;
  exp_t sb[$];
  logic prev_acc = 1'b0;

  always #2 clk = ~clk;

  irq_accept_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ien_set(ien_set), .ien_clr(ien_clr), .ack(ack), .ret(ret),
    .accept(accept), .accept_id(accept_id), .run_level(run_level), .ien(ien)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_accept(input int id, input int lvl);
    exp_t e;
    e.id = id;
    e.lvl = lvl;
    sb.push_back(e);
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_set();
    ien_set = 1'b1; tick(); ien_set = 1'b0;
  endtask

  task automatic pulse_clr();
    ien_clr = 1'b1; tick(); ien_clr = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic pulse_ret();
    ret = 1'b1; tick(); ret = 1'b0;
  endtask

  // monitor: each new acceptance is popped from the scoreboard and compared
  always @(negedge clk) begin
    if (!rst) begin
      if (accept && !prev_acc) begin
        if (sb.size() == 0) begin
          checks++;
          failures++;
          $display("FAIL R6 unexpected acceptance: actual id=%0d expected none", accept_id);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check_eq("R5 accepted id", int'(accept_id), e.id);
          check_eq("R7 level after accept", int'(run_level), e.lvl);
        end
      end
      prev_acc <= accept;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick();
    // R1 reset state
    check_eq("R1 ien", int'(ien), 0);
    check_eq("R1 run_level", int'(run_level), 3);
    check_eq("R1 accept", int'(accept), 0);

    // R1/R4: default level 3 is never taken, even when enabled
    irq_req = 24'(1) << 20;
    pulse_set();
    check_eq("R3 set", int'(ien), 1);
    tick(3);
    check_eq("R4 level 3 refused", int'(accept), 0);

    // R2: address 6 is not a register (would alias register 2 / request 8 if truncated)
    irq_req = irq_req | (24'(1) << 8);
    wr(6, 'h00);
    tick(3);
    check_eq("R2 bad address ignored", int'(accept), 0);

    // R3: disabled blocks acceptance
    pulse_clr();
    check_eq("R3 clear", int'(ien), 0);
    irq_req = '0;
    wr(0, 'hD6);            // req0=2 req1=1 req2=1 req3=3
    irq_req = 24'h00000F;
    tick(3);
    check_eq("R3 disabled refuses", int'(accept), 0);

    // R5/R7: lowest level then lowest index -> request 1 at level 1
    expect_accept(1, 1);
    pulse_set();
    tick();
    check_eq("R7 ien cleared", int'(ien), 0);
    tick(3);
    check_eq("R6 accept held", int'(accept), 1);
    check_eq("R6 id held", int'(accept_id), 1);
    pulse_ack();
    check_eq("R6 released by ack", int'(accept), 0);

    // R4: pending levels 1,1,2 do not interrupt level 1
    pulse_set();
    tick(3);
    check_eq("R4 strict compare", int'(accept), 0);
    expect_accept(5, 0);
    irq_req = irq_req | (24'(1) << 5);
    wr(1, 'hF3);            // req5=0, others 3
    tick(2);
    check_eq("R7 nested level", int'(run_level), 0);
    pulse_ack();

    // R8/R10: unwind
    irq_req = irq_req & ~(24'(1) << 5);
    pulse_ret();
    check_eq("R10 restore level 1", int'(run_level), 1);
    check_eq("R8 ien after return", int'(ien), 1);
    tick(2);
    check_eq("R4 no accept at level 1", int'(accept), 0);
    expect_accept(1, 1);
    pulse_ret();
    check_eq("R8 restore level 3", int'(run_level), 3);
    check_eq("R8 no accept in return cycle", int'(accept), 0);
    tick();
    pulse_ack();

    // R7: acceptance overrides a same-cycle enable set
    pulse_set();
    check_eq("R4 no accept before new request", int'(accept), 0);
    expect_accept(5, 0);
    irq_req = irq_req | (24'(1) << 5);
    ien_set = 1'b1;
    tick();
    ien_set = 1'b0;
    check_eq("R7 accept beats set", int'(ien), 0);
    check_eq("R7 accept present", int'(accept), 1);
    pulse_ack();

    // R10/R9: unwind three levels, last one from an empty stack
    irq_req = '0;
    pulse_ret();
    check_eq("R10 pop to 1", int'(run_level), 1);
    pulse_ret();
    check_eq("R10 pop to 3", int'(run_level), 3);
    pulse_clr();
    pulse_ret();
    check_eq("R9 empty return level", int'(run_level), 3);
    check_eq("R9 empty return ien", int'(ien), 1);

    // R3: set and clear together -> clear
    ien_set = 1'b1; ien_clr = 1'b1;
    tick();
    ien_set = 1'b0; ien_clr = 1'b0;
    check_eq("R3 clear wins", int'(ien), 0);

    // R2/R5: upper fields, equal level 0 on requests 16 and 23 -> 16
    wr(4, 'hFC);            // req16=0
    wr(5, 'h3F);            // req23=0
    irq_req = (24'(1) << 23) | (24'(1) << 16) | (24'(1) << 1);
    expect_accept(16, 0);
    pulse_set();
    tick();
    pulse_ack();

    tick(5);
    check_eq("R6 all expected acceptances seen", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule